// File: doc/BRIEF.md
# Two-Deep Receive Message Slot

This block stores received CAN messages for a single receive slot. It keeps one message location that the host can see and, behind it, one hidden backing location. Two messages can therefore wait unread without either being lost. When the host finishes with the visible message and releases it, a waiting message in the backing location moves forward into the visible location on its own.

An upstream receiver presents each accepted message with a one-cycle write strobe. The host releases the visible message with a one-cycle release strobe. A configuration bit chooses what happens when every location is already occupied: either the newest arrival is dropped, or it replaces the newest stored message. The same block can be built with only one location. In that form it applies the same policy to that single location. Any arrival that finds the slot full raises a sticky overrun flag.

Top module: `rx_two_deep_slot`

## Requirements
- R1: After reset, `primaryValid` and `overrunFlag` are 0 and `primaryData` is all zeros.
- R2: A message written while the visible location is empty appears on `primaryData` with `primaryValid` = 1 on the cycle after the write strobe.
- R3: With SLOT_DEPTH = 2, a message written while the visible location holds an unread message and the backing location is empty goes to the backing location. `primaryData` is unchanged.
- R4: A release of a valid visible message takes effect on the next cycle. If a message waits in the backing location, that message becomes `primaryData` and `primaryValid` stays 1. Otherwise `primaryValid` falls to 0.
- R5: With SLOT_DEPTH = 2 and `overwriteEn` = 0, a message that arrives while both locations are occupied is discarded. Neither stored message changes.
- R6: With SLOT_DEPTH = 2 and `overwriteEn` = 1, a message that arrives while both locations are occupied replaces the backing message only. `primaryData` is unchanged.
- R7: `overrunFlag` is set on the cycle after any write that finds every location occupied, in both depths and under both overwrite settings. It stays set until `ovrClear` is high at an edge. If a new loss and `ovrClear` occur in the same cycle, the flag stays set.
- R8: With SLOT_DEPTH = 1 and `overwriteEn` = 1, a message written while the slot is unread replaces `primaryData`, and `primaryValid` stays 1.
- R9: With SLOT_DEPTH = 1 and `overwriteEn` = 0, a message written while the slot is unread is dropped, and `primaryData` is unchanged.
- R10: When a write and a release arrive in the same cycle, the release and any refill are applied first. The incoming message is then placed by the rules of R2 to R9.
- R11: A release while `primaryValid` = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| msgWrite | input | 1 | One-cycle strobe: a received message is on `msgData` |
| msgData | input | PAYLOAD_W | Payload of the incoming message |
| hostRelease | input | 1 | One-cycle strobe: the host releases the visible message |
| overwriteEn | input | 1 | 1 = an arrival into a full slot overwrites; 0 = it is dropped |
| ovrClear | input | 1 | Clears `overrunFlag` |
| primaryData | output | PAYLOAD_W | Payload held in the visible location |
| primaryValid | output | 1 | The visible location holds an unread message |
| overrunFlag | output | 1 | Sticky: an arrival found every location occupied |

## Verification
The bench builds two copies with an 8-bit payload, one with SLOT_DEPTH = 2 and one with SLOT_DEPTH = 1. Both copies receive the same stimulus. The narrow payload keeps every message value distinct and readable in failure lines. Having both depths side by side puts the single-deep overwrite and drop paths next to the two-deep refill path.

The bench sweeps every starting occupancy (zero, one or two messages) against every combination of write, release and overwrite setting. After each combination it checks that the overrun flag holds, then drains the slot through releases to show which payloads were kept.

// File: rtl/rx_slot_pkg.sv
`timescale 1ns/1ps
package rx_slot_pkg;
  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic primFromIn;   // load visible location from incoming payload
    logic primFromBuf;  // load visible location from backing location
    logic bufFromIn;    // load backing location from incoming payload
  } slotStrobes_t;
endpackage

// File: rtl/rx_slot_ctrl.sv
`timescale 1ns/1ps
module rx_slot_ctrl
  import rx_slot_pkg::*;
#(
  parameter int SLOT_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         msgWrite,
  input  logic         hostRelease,
  input  logic         overwriteEn,
  input  logic         ovrClear,
  output slotStrobes_t strb,
  output logic         primValid,
  output logic         overrunFlag
);
  localparam bit HAS_BUF = (SLOT_DEPTH > 1);

  logic primValidQ, bufValidQ, overrunQ;
  logic primAfterRel, bufAfterRel, slotFull, lossEvent;
  slotStrobes_t strbC;

  // Release and refill are resolved first, then the arrival is placed (R10)
  always_comb begin
    primAfterRel = primValidQ;
    bufAfterRel  = bufValidQ;
    strbC        = '0;
    lossEvent    = 1'b0;
    if (hostRelease && primValidQ) begin
      strbC.primFromBuf = bufValidQ;
      primAfterRel      = bufValidQ;
      bufAfterRel       = 1'b0;
    end
    slotFull = HAS_BUF ? bufAfterRel : primAfterRel;
    if (msgWrite) begin
      if (!primAfterRel) begin
        strbC.primFromIn = 1'b1;
      end else if (!slotFull) begin
        strbC.bufFromIn = 1'b1;
      end else begin
        lossEvent = 1'b1;
        if (overwriteEn) begin
          if (HAS_BUF) strbC.bufFromIn  = 1'b1;
          else         strbC.primFromIn = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primValidQ <= 1'b0;
      overrunQ   <= 1'b0;
    end else begin
      primValidQ <= primAfterRel | strbC.primFromIn;
      if (lossEvent)     overrunQ <= 1'b1;
      else if (ovrClear) overrunQ <= 1'b0;
    end
  end

  generate
    if (HAS_BUF) begin : g_bufValid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bufValidQ <= 1'b0;
        else       bufValidQ <= bufAfterRel | strbC.bufFromIn;
      end
    end else begin : g_noBufValid
      assign bufValidQ = 1'b0;
    end
  endgenerate

  assign strb        = strbC;
  assign primValid   = primValidQ;
  assign overrunFlag = overrunQ;

  // R3: backing location is only occupied behind an occupied visible location
  p_buf_needs_prim_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufValidQ |-> primValidQ);
  // R2: a write into an empty visible location makes it valid
  p_empty_write_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!primValidQ && msgWrite) |=> primValidQ);
  // R4: refill keeps the visible location valid
  p_refill_keeps_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRelease && bufValidQ) |=> primValidQ);
  // R4: a release with nothing waiting empties the slot
  p_release_empties_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hostRelease && primValidQ && !bufValidQ && !msgWrite) |=> !primValidQ);
  // R7: a write into a full slot with no release raises the overrun flag
  p_full_write_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (msgWrite && !hostRelease && (HAS_BUF ? bufValidQ : primValidQ)) |=> overrunQ);
  // R7: overrun flag is sticky until cleared
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (overrunQ && !ovrClear) |=> overrunQ);
endmodule

// File: rtl/rx_slot_data.sv
`timescale 1ns/1ps
module rx_slot_data
  import rx_slot_pkg::*;
#(
  parameter int PAYLOAD_W  = 64,
  parameter int SLOT_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotStrobes_t         strb,
  input  logic [PAYLOAD_W-1:0] inData,
  output logic [PAYLOAD_W-1:0] primData
);
  logic [PAYLOAD_W-1:0] primDataQ, bufDataQ;

  generate
    if (SLOT_DEPTH > 1) begin : g_bufData
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               bufDataQ <= '0;
        else if (strb.bufFromIn) bufDataQ <= inData;
      end
    end else begin : g_noBufData
      assign bufDataQ = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 primDataQ <= '0;
    else if (strb.primFromBuf) primDataQ <= bufDataQ;
    else if (strb.primFromIn)  primDataQ <= inData;
  end

  assign primData = primDataQ;

  // R4/R10: the two sources of the visible location are never chosen together
  p_one_prim_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.primFromBuf && strb.primFromIn));
endmodule

// File: rtl/rx_two_deep_slot.sv
`timescale 1ns/1ps
module rx_two_deep_slot
  import rx_slot_pkg::*;
#(
  parameter int PAYLOAD_W  = 64,
  parameter int SLOT_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msgWrite,
  input  logic [PAYLOAD_W-1:0] msgData,
  input  logic                 hostRelease,
  input  logic                 overwriteEn,
  input  logic                 ovrClear,
  output logic [PAYLOAD_W-1:0] primaryData,
  output logic                 primaryValid,
  output logic                 overrunFlag
);
  slotStrobes_t strb;

  rx_slot_ctrl #(.SLOT_DEPTH(SLOT_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .msgWrite(msgWrite), .hostRelease(hostRelease),
    .overwriteEn(overwriteEn), .ovrClear(ovrClear), .strb(strb),
    .primValid(primaryValid), .overrunFlag(overrunFlag)
  );

  rx_slot_data #(.PAYLOAD_W(PAYLOAD_W), .SLOT_DEPTH(SLOT_DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(msgData), .primData(primaryData)
  );

  // R3/R5/R6/R9: an arrival without release never disturbs a valid visible message
  p_primary_kept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (primaryValid && msgWrite && !hostRelease && (SLOT_DEPTH > 1 || !overwriteEn))
      |=> $stable(primaryData));
  // R11: releasing an empty slot keeps it empty
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!primaryValid && hostRelease && !msgWrite) |=> !primaryValid);
endmodule

// File: tb/rx_two_deep_slot_tb.sv
`timescale 1ns/1ps
module rx_two_deep_slot_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgWrite = 1'b0, hostRelease = 1'b0, overwriteEn = 1'b0, ovrClear = 1'b0;
  logic [W-1:0] msgData = '0;
  logic [W-1:0] dataA, dataB;
  logic validA, validB, ovrA, ovrB;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] nextVal = 8'h10;

  // model: index 0 = depth 2, index 1 = depth 1
  logic [W-1:0] m [2][2];
  int mN [2];
  bit mOv [2];
  int mDepth [2] = '{2, 1};

  always #4 clk = ~clk;  // 125 MHz

  rx_two_deep_slot #(.PAYLOAD_W(W), .SLOT_DEPTH(2)) dut_i (
    .clk(clk), .rstN(rstN), .msgWrite(msgWrite), .msgData(msgData),
    .hostRelease(hostRelease), .overwriteEn(overwriteEn), .ovrClear(ovrClear),
    .primaryData(dataA), .primaryValid(validA), .overrunFlag(ovrA)
  );

  rx_two_deep_slot #(.PAYLOAD_W(W), .SLOT_DEPTH(1)) dutSingle_i (
    .clk(clk), .rstN(rstN), .msgWrite(msgWrite), .msgData(msgData),
    .hostRelease(hostRelease), .overwriteEn(overwriteEn), .ovrClear(ovrClear),
    .primaryData(dataB), .primaryValid(validB), .overrunFlag(ovrB)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "depth2 valid", int'(validA), int'(mN[0] > 0));
    if (mN[0] > 0) cmp(tag, "depth2 data", int'(dataA), int'(m[0][0]));
    cmp(tag, "depth2 overrun", int'(ovrA), int'(mOv[0]));
    cmp(tag, "depth1 valid", int'(validB), int'(mN[1] > 0));
    if (mN[1] > 0) cmp(tag, "depth1 data", int'(dataB), int'(m[1][0]));
    cmp(tag, "depth1 overrun", int'(ovrB), int'(mOv[1]));
  endtask

  // expected behaviour from the requirements: release first, then placement
  task automatic modelStep(input bit w, input bit rel, input bit ov, input bit clr,
                           input logic [W-1:0] d);
    for (int k = 0; k < 2; k++) begin
      bit lost = 1'b0;
      if (rel && mN[k] > 0) begin
        m[k][0] = m[k][1];
        mN[k]--;
      end
      if (w) begin
        if (mN[k] < mDepth[k]) begin
          m[k][mN[k]] = d;
          mN[k]++;
        end else begin
          lost = 1'b1;
          if (ov) m[k][mDepth[k]-1] = d;
        end
      end
      if (clr) mOv[k] = 1'b0;
      if (lost) mOv[k] = 1'b1;
    end
  endtask

  task automatic step(input bit w, input bit rel, input bit ov, input bit clr);
    msgWrite = w; hostRelease = rel; overwriteEn = ov; ovrClear = clr;
    msgData = nextVal;
    modelStep(w, rel, ov, clr, nextVal);
    if (w) nextVal = nextVal + 8'h01;
    @(negedge clk);
    msgWrite = 1'b0; hostRelease = 1'b0; overwriteEn = 1'b0; ovrClear = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 2; k++) begin
      mN[k] = 0; mOv[k] = 1'b0; m[k][0] = '0; m[k][1] = '0;
    end
  endtask

  function automatic string tagFor(int occ, bit w, bit rel, bit ov);
    if (w && rel) return "R10";
    if (!w && rel) return (occ == 0) ? "R11" : "R4";
    if (!w) return "R7";
    if (occ == 0) return "R2";
    if (occ == 1) return ov ? "R3/R8" : "R3/R9";
    return ov ? "R6/R8" : "R5/R9";
  endfunction

  initial begin
    @(negedge clk);
    doReset();
    // R1: reset state, data compared directly
    cmp("R1", "depth2 valid", int'(validA), 0);
    cmp("R1", "depth2 data", int'(dataA), 0);
    cmp("R1", "depth2 overrun", int'(ovrA), 0);
    cmp("R1", "depth1 valid", int'(validB), 0);
    cmp("R1", "depth1 data", int'(dataB), 0);
    cmp("R1", "depth1 overrun", int'(ovrB), 0);

    // sweep: starting occupancy x write x release x overwrite
    for (int occ = 0; occ < 3; occ++) begin
      for (int wi = 0; wi < 2; wi++) begin
        for (int ri = 0; ri < 2; ri++) begin
          for (int oi = 0; oi < 2; oi++) begin
            doReset();
            for (int k = 0; k < occ; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
            step(1'b0, 1'b0, 1'b0, 1'b1);
            checkAll("R2");
            step(bit'(wi), bit'(ri), bit'(oi), 1'b0);
            checkAll(tagFor(occ, bit'(wi), bit'(ri), bit'(oi)));
            step(1'b0, 1'b0, 1'b0, 1'b0);
            checkAll("R7");  // overrun sticky
            for (int k = 0; k < 3; k++) begin
              step(1'b0, 1'b1, 1'b0, 1'b0);
              checkAll("R4");  // drain shows what was kept
            end
          end
        end
      end
    end

    // R7: loss and clear in the same cycle, flag stays set
    doReset();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    checkAll("R7");
    step(1'b0, 1'b0, 1'b0, 1'b1);
    checkAll("R7");

    // R10: write plus release on a full two-deep slot, then drain
    doReset();
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    checkAll("R10");
    step(1'b0, 1'b1, 1'b0, 1'b0);
    checkAll("R10");
    step(1'b0, 1'b1, 1'b0, 1'b0);
    checkAll("R10");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule